// File: doc/BRIEF.md
# Configurable Majority Coincidence Trigger

This block takes per-clock hit bits from sixteen detector layers, sorted into five trigger classes, and forms one registered coincidence output per channel for each class. The classes are wire doublet (four layers), wire triplet (three layers), strip doublet (four layers), strip triplet (three layers) and an inner/forward station class (two layers). Every layer passes through its own programmable alignment delay of 0 to 15 clocks, so that hits from layers with different arrival times can be lined up before the coincidence is taken.

For each class and channel, the block counts the layers that have a hit in that channel or in one of its two immediate neighbours. This tolerates inclined tracks. The channel fires when the count reaches the class threshold. The thresholds reset to 3-of-4 for doublets, 2-of-3 for triplets and 1-of-2 for the inner/forward class. Each threshold can be changed at run time through a simple register write port, and so can each class enable, for example to select a looser 1-of-n condition. Outputs appear a fixed programmed-delay-plus-two cycles after the hits are sampled.

Top module: `mct_top`

## Requirements
- R1: After an asynchronous reset all outputs are 0 and all layer delays are 0. Every class is enabled, with threshold 3 for wire doublet and strip doublet, 2 for wire triplet and strip triplet, and 1 for inner/forward.
- R2: A write with `cfg_wr_i` high is decoded as follows. Address 0..15 loads the delay of layer N from `cfg_data_i[3:0]`. Address 16..20 configures class 0..4 (wire doublet, wire triplet, strip doublet, strip triplet, inner/forward): `cfg_data_i[2:0]` is the threshold and `cfg_data_i[7]` is the enable. Writes to addresses 21..31 change nothing.
- R3: A hit sampled at clock edge E on a layer with delay d contributes to the trigger output that is updated at edge E+d+2, and to no earlier output.
- R4: A layer counts toward channel c if it has a hit in channel c-1, c or c+1. Channels beyond the edges are treated as empty.
- R5: A class output bit is 1 when the number of contributing layers is at least the class threshold. At reset this gives 3-of-4 for the doublet classes.
- R6: At reset the triplet classes fire on 2-of-3 layers.
- R7: At reset the inner/forward class fires on 1-of-2 layers. A threshold of 1 selects a loose 1-of-n condition on any class.
- R8: A class with its enable at 0 drives all of its output bits to 0.
- R9: A threshold of 0 never fires. A threshold above the layer count of a class never fires.
- R10: Delays are per layer, so hits from different layers coincide only when their delayed arrival times match.
- R11: Hit port bit layer*NCH+channel carries layer `layer` of the class, channel `channel`. Output bit c is channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address |
| cfg_data_i | input | 8 | Configuration write data |
| wd_hits_i | input | 4*NCH | Wire doublet hits |
| wt_hits_i | input | 3*NCH | Wire triplet hits |
| sd_hits_i | input | 4*NCH | Strip doublet hits |
| st_hits_i | input | 3*NCH | Strip triplet hits |
| fi_hits_i | input | 2*NCH | Inner/forward hits |
| wd_trig_o | output | NCH | Wire doublet trigger per channel |
| wt_trig_o | output | NCH | Wire triplet trigger per channel |
| sd_trig_o | output | NCH | Strip doublet trigger per channel |
| st_trig_o | output | NCH | Strip triplet trigger per channel |
| fi_trig_o | output | NCH | Inner/forward trigger per channel |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Edge channels 0 and 7.** A design that wrapped the neighbour window around would fire on the opposite edge.
- **Patterns exactly one layer short of the threshold.** An off-by-one compare would trigger on them.
- **Per-layer delays, in both directions.** A delayed layer must coincide with undelayed layers driven later. Hits driven together must fail to coincide. A design that shared one delay among the layers, or tapped one stage off, misses one of the two cases.
- **Latency.** The output is sampled one cycle early and on time to catch an extra or missing pipeline stage.
- **Configuration edge cases.** These are a disabled class, a zero threshold and writes to unused addresses. A loose decoder would corrupt a live class on such writes, which shows up as a changed trigger pattern.

// File: rtl/mct_pkg.sv
package mct_pkg;

  localparam int NUM_CLASS  = 5;
  localparam int NUM_LAYERS = 16;
  localparam int CFG_ADDR_W = 5;
  localparam int CFG_DATA_W = 8;
  localparam int THR_W      = 3;

  // class order: 0 wire doublet, 1 wire triplet, 2 strip doublet,
  // 3 strip triplet, 4 inner/forward
  function automatic int cls_layers(input int k);
    case (k)
      0, 2:    return 4;
      1, 3:    return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int cls_base(input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += cls_layers(i);
    return acc;
  endfunction

  function automatic int cls_thr_default(input int k);
    case (k)
      0, 2:    return 3;
      1, 3:    return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/mct_cfg_regs.sv
module mct_cfg_regs
  import mct_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [CFG_ADDR_W-1:0]       wr_addr_i,
  input  logic [CFG_DATA_W-1:0]       wr_data_i,
  output logic [NUM_LAYERS*DLY_W-1:0] dly_o,
  output logic [NUM_CLASS*THR_W-1:0]  thr_o,
  output logic [NUM_CLASS-1:0]        en_o
);

  logic [NUM_LAYERS*DLY_W-1:0] dly_q, dly_d;
  logic [NUM_CLASS*THR_W-1:0]  thr_q, thr_d;
  logic [NUM_CLASS-1:0]        en_q, en_d;
  logic                        load;

  assign load = wr_en_i;

  always_comb begin
    dly_d = dly_q;
    thr_d = thr_q;
    en_d  = en_q;
    for (int l = 0; l < NUM_LAYERS; l++) begin
      if (wr_addr_i == CFG_ADDR_W'(l))
        dly_d[l*DLY_W +: DLY_W] = wr_data_i[DLY_W-1:0];
    end
    for (int k = 0; k < NUM_CLASS; k++) begin
      if (wr_addr_i == CFG_ADDR_W'(NUM_LAYERS + k)) begin
        thr_d[k*THR_W +: THR_W] = wr_data_i[THR_W-1:0];
        en_d[k]                 = wr_data_i[CFG_DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      en_q  <= '1;
      for (int k = 0; k < NUM_CLASS; k++)
        thr_q[k*THR_W +: THR_W] <= THR_W'(cls_thr_default(k));
    end else if (load) begin
      dly_q <= dly_d;
      thr_q <= thr_d;
      en_q  <= en_d;
    end
  end

  assign dly_o = dly_q;
  assign thr_o = thr_q;
  assign en_o  = en_q;

endmodule

// File: rtl/mct_delay_line.sv
module mct_delay_line #(
  parameter int NCH   = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hit_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic [NCH-1:0]   tap_o
);

  localparam int DEPTH = 1 << DLY_W;

  logic [NCH-1:0] sr_q [DEPTH];
  logic [NCH-1:0] sr_d [DEPTH];
  logic [NCH-1:0] tap_q, tap_d;

  always_comb begin
    sr_d[0] = hit_i;
    for (int i = 1; i < DEPTH; i++) sr_d[i] = sr_q[i-1];
    tap_d = sr_q[sel_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
      tap_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= sr_d[i];
      tap_q <= tap_d;
    end
  end

  assign tap_o = tap_q;

endmodule

// File: rtl/mct_coinc.sv
module mct_coinc #(
  parameter int NCH   = 8,
  parameter int NLAY  = 4,
  parameter int THR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLAY*NCH-1:0] hits_i,
  input  logic [THR_W-1:0]    thr_i,
  input  logic                en_i,
  output logic [NCH-1:0]      trig_o
);

  logic [NCH-1:0] fire_d, fire_q;

  always_comb begin
    logic [NCH+1:0] pad;
    int             cnt;
    fire_d = '0;
    for (int c = 0; c < NCH; c++) begin
      cnt = 0;
      for (int l = 0; l < NLAY; l++) begin
        pad = {1'b0, hits_i[l*NCH +: NCH], 1'b0};
        if (|pad[c +: 3]) cnt = cnt + 1;
      end
      fire_d[c] = en_i && (thr_i != '0) && (cnt >= int'(thr_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= '0;
    else        fire_q <= fire_d;
  end

  assign trig_o = fire_q;

endmodule

// File: rtl/mct_top.sv
module mct_top
  import mct_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DLY_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_DATA_W-1:0] cfg_data_i,
  input  logic [4*NCH-1:0]      wd_hits_i,
  input  logic [3*NCH-1:0]      wt_hits_i,
  input  logic [4*NCH-1:0]      sd_hits_i,
  input  logic [3*NCH-1:0]      st_hits_i,
  input  logic [2*NCH-1:0]      fi_hits_i,
  output logic [NCH-1:0]        wd_trig_o,
  output logic [NCH-1:0]        wt_trig_o,
  output logic [NCH-1:0]        sd_trig_o,
  output logic [NCH-1:0]        st_trig_o,
  output logic [NCH-1:0]        fi_trig_o
);

  logic [NUM_LAYERS*NCH-1:0]   raw_flat;
  logic [NUM_LAYERS*NCH-1:0]   tap_flat;
  logic [NUM_LAYERS*DLY_W-1:0] dly_flat;
  logic [NUM_CLASS*THR_W-1:0]  thr_flat;
  logic [NUM_CLASS-1:0]        cls_en;
  logic [NUM_CLASS*NCH-1:0]    trig_flat;

  assign raw_flat = {fi_hits_i, st_hits_i, sd_hits_i, wt_hits_i, wd_hits_i};

  mct_cfg_regs #(.DLY_W(DLY_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_wr_i),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (cfg_data_i),
    .dly_o     (dly_flat),
    .thr_o     (thr_flat),
    .en_o      (cls_en)
  );

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    mct_delay_line #(.NCH(NCH), .DLY_W(DLY_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (raw_flat[l*NCH +: NCH]),
      .sel_i (dly_flat[l*DLY_W +: DLY_W]),
      .tap_o (tap_flat[l*NCH +: NCH])
    );
  end

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
    localparam int NL   = cls_layers(k);
    localparam int BASE = cls_base(k);
    mct_coinc #(.NCH(NCH), .NLAY(NL), .THR_W(THR_W)) u_coinc (
      .clk    (clk),
      .rst_n  (rst_n),
      .hits_i (tap_flat[BASE*NCH +: NL*NCH]),
      .thr_i  (thr_flat[k*THR_W +: THR_W]),
      .en_i   (cls_en[k]),
      .trig_o (trig_flat[k*NCH +: NCH])
    );
  end

  assign wd_trig_o = trig_flat[0*NCH +: NCH];
  assign wt_trig_o = trig_flat[1*NCH +: NCH];
  assign sd_trig_o = trig_flat[2*NCH +: NCH];
  assign st_trig_o = trig_flat[3*NCH +: NCH];
  assign fi_trig_o = trig_flat[4*NCH +: NCH];

endmodule

// File: rtl/mct_chk.sv
module mct_chk
  import mct_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DLY_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_wr_i,
  input logic [CFG_ADDR_W-1:0]       cfg_addr_i,
  input logic [CFG_DATA_W-1:0]       cfg_data_i,
  input logic [NUM_LAYERS*DLY_W-1:0] dly_flat,
  input logic [NUM_CLASS*THR_W-1:0]  thr_flat,
  input logic [NUM_CLASS-1:0]        cls_en,
  input logic [NUM_LAYERS*NCH-1:0]   tap_flat,
  input logic [NUM_CLASS*NCH-1:0]    trig_flat
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (trig_flat == '0 && dly_flat == '0));

  assert_unused_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && cfg_addr_i >= CFG_ADDR_W'(NUM_LAYERS + NUM_CLASS))
      |=> ($stable(dly_flat) && $stable(thr_flat) && $stable(cls_en)));

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_l
    assert_dly_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && cfg_addr_i == CFG_ADDR_W'(l))
        |=> (dly_flat[l*DLY_W +: DLY_W] == $past(cfg_data_i[DLY_W-1:0])));
  end

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_k
    localparam int NL   = cls_layers(k);
    localparam int BASE = cls_base(k);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cls_en[k] |=> (trig_flat[k*NCH +: NCH] == '0));

    assert_thr_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_flat[k*THR_W +: THR_W] == '0) |=> (trig_flat[k*NCH +: NCH] == '0));

    assert_needs_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_flat[BASE*NCH +: NL*NCH] == '0) |=> (trig_flat[k*NCH +: NCH] == '0));
  end

endmodule

bind mct_top mct_chk #(.NCH(NCH), .DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_data_i (cfg_data_i),
  .dly_flat   (dly_flat),
  .thr_flat   (thr_flat),
  .cls_en     (cls_en),
  .tap_flat   (tap_flat),
  .trig_flat  (trig_flat)
);

// File: tb/mct_top_tb_top.sv
module mct_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam logic [3:0] NO = 4'hF;

  logic clk, rst_n, cfg_wr;
  logic [4:0] cfg_addr;
  logic [7:0] cfg_data;
  logic [4*NCH-1:0] wd_hits, sd_hits;
  logic [3*NCH-1:0] wt_hits, st_hits;
  logic [2*NCH-1:0] fi_hits;
  logic [NCH-1:0] wd_trig, wt_trig, sd_trig, st_trig, fi_trig;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  mct_top #(.NCH(NCH), .DLY_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .wd_hits_i(wd_hits), .wt_hits_i(wt_hits),
    .sd_hits_i(sd_hits), .st_hits_i(st_hits), .fi_hits_i(fi_hits),
    .wd_trig_o(wd_trig), .wt_trig_o(wt_trig), .sd_trig_o(sd_trig),
    .st_trig_o(st_trig), .fi_trig_o(fi_trig)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // entry = {p3, p2, p1, p0, thr, cls}; p = channel hit on that layer, F = none
  localparam logic [21:0] VECS [12] = '{
    {NO,   4'd2, 4'd2, 4'd2, 3'd3, 3'd0},   // R5 three of four
    {NO,   NO,   4'd3, 4'd2, 3'd3, 3'd0},   // R5 one short
    {4'd2, 4'd3, 4'd2, 4'd1, 3'd3, 3'd0},   // R4 inclined track
    {NO,   NO,   4'd1, 4'd0, 3'd2, 3'd1},   // R6 low edge
    {NO,   4'd7, 4'd7, 4'd7, 3'd2, 3'd1},   // R6 high edge
    {4'd5, 4'd5, 4'd5, 4'd5, 3'd3, 3'd2},   // R5 strip doublet
    {NO,   NO,   4'd4, 4'd0, 3'd2, 3'd3},   // R6 too far apart
    {NO,   NO,   NO,   4'd3, 3'd1, 3'd4},   // R7 one of two
    {NO,   NO,   4'd5, 4'd3, 3'd2, 3'd4},   // R4 shared neighbour
    {NO,   NO,   NO,   4'd6, 3'd1, 3'd0},   // R7 loose doublet
    {NO,   4'd2, 4'd2, 4'd2, 3'd3, 3'd3},   // R6 raised triplet
    {4'd0, 4'd0, 4'd0, 4'd0, 3'd4, 3'd0}    // R5 all four, edge
  };

  function automatic int nlay(input int k);
    return (k == 0 || k == 2) ? 4 : (k == 4) ? 2 : 3;
  endfunction

  function automatic logic [NCH-1:0] model(input int k, input int thr,
                                           input logic [15:0] pos);
    logic [NCH-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++) begin
      int cnt;
      cnt = 0;
      for (int l = 0; l < nlay(k); l++) begin
        int p;
        p = int'(pos[l*4 +: 4]);
        if (p != 15 && p - c <= 1 && c - p <= 1) cnt++;
      end
      r[c] = (thr != 0) && (cnt >= thr);
    end
    return r;
  endfunction

  task automatic drive(input int k, input logic [15:0] pos);
    logic [4*NCH-1:0] v;
    v = '0;
    for (int l = 0; l < nlay(k); l++)
      if (pos[l*4 +: 4] != 4'hF) v[l*NCH + int'(pos[l*4 +: 4])] = 1'b1;
    case (k)
      0: wd_hits = v;
      1: wt_hits = v[3*NCH-1:0];
      2: sd_hits = v;
      3: st_hits = v[3*NCH-1:0];
      default: fi_hits = v[2*NCH-1:0];
    endcase
  endtask

  task automatic clear_hits();
    wd_hits = '0; wt_hits = '0; sd_hits = '0; st_hits = '0; fi_hits = '0;
  endtask

  function automatic logic [NCH-1:0] trig_of(input int k);
    case (k)
      0: return wd_trig;
      1: return wt_trig;
      2: return sd_trig;
      3: return st_trig;
      default: return fi_trig;
    endcase
  endfunction

  task automatic chk(input string req, input int k, input logic [NCH-1:0] exp);
    tests++;
    if (trig_of(k) !== exp) begin
      fails++;
      $display("FAIL %s class %0d: got %b expected %b", req, k, trig_of(k), exp);
    end
  endtask

  task automatic chk_all(input string req, input int k, input logic [NCH-1:0] exp);
    for (int j = 0; j < 5; j++) chk(req, j, (j == k) ? exp : '0);
  endtask

  task automatic cfg_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // drive one pulse, sampled at E0; result visible after E0+2 with delay 0
  task automatic pulse(input int k, input logic [15:0] pos);
    @(negedge clk); drive(k, pos);
    @(negedge clk); clear_hits();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    cfg_wr = 0; cfg_addr = '0; cfg_data = '0;
    clear_hits();
    rst_n = 1'b0;
    #1;
    // R1: reset state
    for (int j = 0; j < 5; j++) chk("R1 reset", j, '0);
    do_reset();
    for (int j = 0; j < 5; j++) chk("R1 after reset", j, '0);

    // R1 defaults: doublet 3, triplet 2, inner/forward 1
    pulse(0, {NO, 4'd2, 4'd2, 4'd2});
    chk_all("R1 R5 default doublet", 0, 8'b0000_1110);
    pulse(0, {NO, NO, 4'd2, 4'd2});
    chk_all("R1 R5 default doublet short", 0, '0);
    pulse(1, {NO, NO, 4'd4, 4'd4});
    chk_all("R1 R6 default triplet", 1, 8'b0011_1000);
    pulse(4, {NO, NO, NO, 4'd0});
    chk_all("R1 R7 default forward", 4, 8'b0000_0011);

    // table walk, R11 layout through drive()
    for (int i = 0; i < 12; i++) begin
      int k, t;
      k = int'(VECS[i][2:0]);
      t = int'(VECS[i][5:3]);
      cfg_write(16 + k, {1'b1, 4'b0, 3'(t)});
      pulse(k, VECS[i][21:6]);
      chk_all("R4 R5 R11 table", k, model(k, t, VECS[i][21:6]));
    end

    do_reset();

    // R3 latency with delay 5 on wire doublet layers 0..2
    for (int l = 0; l < 3; l++) cfg_write(l, 8'd5);
    @(negedge clk); drive(0, {NO, 4'd4, 4'd4, 4'd4});
    @(negedge clk); clear_hits();
    repeat (6) @(negedge clk);
    chk("R3 not before d+2", 0, '0);
    @(negedge clk);
    chk("R3 at d+2", 0, 8'b0011_1000);
    @(negedge clk);
    chk("R3 single pulse", 0, '0);
    for (int l = 0; l < 3; l++) cfg_write(l, 8'd0);

    // R10 per-layer alignment: layer 0 delayed by 3
    cfg_write(0, 8'd3);
    @(negedge clk); drive(0, {NO, NO, NO, 4'd4});
    @(negedge clk); clear_hits();
    @(negedge clk);
    @(negedge clk); drive(0, {NO, 4'd4, 4'd4, NO});
    @(negedge clk); clear_hits();
    repeat (2) @(negedge clk);
    chk("R10 aligned by delay", 0, 8'b0011_1000);
    pulse(0, {NO, 4'd4, 4'd4, 4'd4});
    chk("R10 misaligned same cycle", 0, '0);
    @(negedge clk);
    chk("R10 late layer alone", 0, '0);
    cfg_write(0, 8'd0);

    // R2 unused addresses leave config alone
    for (int a = 21; a < 32; a++) cfg_write(a, 8'h00);
    pulse(0, {NO, 4'd6, 4'd6, 4'd6});
    chk_all("R2 unused address ignored", 0, 8'b1110_0000);

    // R8 disable
    cfg_write(18, 8'h03);
    pulse(2, {4'd1, 4'd1, 4'd1, 4'd1});
    chk_all("R8 disabled class", 2, '0);

    // R9 threshold zero and above layer count
    cfg_write(17, 8'h80);
    pulse(1, {NO, 4'd3, 4'd3, 4'd3});
    chk_all("R9 threshold zero", 1, '0);
    cfg_write(20, 8'h83);
    pulse(4, {NO, NO, 4'd3, 4'd3});
    chk_all("R9 threshold above layers", 4, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule